// File: doc/BRIEF.md
# Service Routine Entry and Return Sequencer

This block is the multi-cycle control unit of a 16-bit processor that carries out every state change needed to enter a service routine and to leave one. It owns the processor status word, the program counter, the live stack pointer (R6) and the two parked stack pointers, one for supervisor mode and one for user mode. A routine is entered in one of two ways. The first is a software trap instruction, which uses an 8-bit vector into a table at the bottom of memory. The second is an already accepted interrupt, which brings an 8-bit vector into a second table and a 3-bit priority. The return instruction undoes an entry.

On entry the block switches to the supervisor stack when it was running in user mode. It then pushes the old status word and the saved program counter, fetches the routine address from the vector table and loads it into the program counter. On return it pops the program counter and then the status word. When the restored status word is in user mode, it swaps the stack pointers back. Memory is reached through a single-port request interface, and read data arrives the cycle after the read request.

Top module: `svc_seq`

## Requirements
- R1: After reset, the status word is 0x0000 (supervisor, priority 0), the PC is RST_PC, R6 and the saved supervisor pointer are RST_SSP, the saved user pointer is RST_USP, and busy_o, done_o, priv_viol_o and mem_req_o are low.
- R2: An instruction is a trap when bits 15:12 are 1111 and bits 11:8 are zero. A word with opcode 1111 and nonzero bits 11:8 starts nothing, makes no memory access and changes no state.
- R3: An entry writes the old status word at R6-1 first, then writes the PC at R6-2. R6 ends two below its value at the start of the pushes.
- R4: A trap reads the word at address {8'h00, bits 7:0} and loads it into the PC.
- R5: An interrupt reads the word at 0x0100 + vector and loads it into the PC. The priority field (bits 10:8) takes the request priority and bit 15 is cleared.
- R6: A trap clears bit 15 of the status word and leaves bits 10:8 unchanged.
- R7: An entry started in user mode (bit 15 = 1) copies R6 into the saved user pointer and performs the pushes on the stack named by the saved supervisor pointer.
- R8: A return (opcode 1000, bits 11:0 zero) issued in supervisor mode reads the PC from R6, then reads the status word from R6+1. R6 ends two higher and no write is made.
- R9: When the restored status word has bit 15 set, the return stores the post-pop R6 into the saved supervisor pointer and reloads R6 from the saved user pointer.
- R10: A return issued in user mode raises priv_viol_o for exactly one cycle, makes no memory access and leaves all state unchanged. Opcode 1000 with nonzero low bits raises nothing.
- R11: An interrupt offered in the same cycle as an instruction wins, and the instruction is dropped. Any request offered while busy_o is high is ignored.
- R12: done_o is a single-cycle pulse. It occurs in the fifth cycle after the request cycle for an entry and in the fourth cycle for a return, and all state is already updated when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | instr_i holds a decoded instruction for this cycle |
| instr_i | input | 16 | Instruction word |
| irq_req_i | input | 1 | Accepted interrupt request |
| irq_vec_i | input | 8 | Interrupt vector |
| irq_prio_i | input | 3 | Priority of the accepted interrupt |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| psr_o | output | 16 | Status word |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Live stack pointer R6 |
| saved_ssp_o | output | 16 | Parked supervisor stack pointer |
| saved_usp_o | output | 16 | Parked user stack pointer |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Sequence finished (one cycle) |
| priv_viol_o | output | 1 | Return attempted in user mode (one cycle) |

## Verification
The two functions that can land in the same cycle are interrupt entry and instruction-driven entry. The bench offers an interrupt and a valid trap word together in the same cycle. In the next cycle, while the block is busy, it offers both again. It then judges the outcome from the memory traffic: exactly two writes and one read, with the read at the interrupt table address, plus the priority taken from the interrupt. The same check confirms that no second sequence follows.

// File: rtl/svc_seq_pkg.sv
package svc_seq_pkg;
  localparam int unsigned DW        = 16;
  localparam int unsigned PRIV_BIT  = 15;
  localparam int unsigned PL_LSB    = 8;
  localparam int unsigned PL_W      = 3;
  localparam logic [3:0]  OP_TRAP   = 4'hF;
  localparam logic [3:0]  OP_RET    = 4'h8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PSR,
    ST_PUSH_PC,
    ST_FETCH,
    ST_LOAD,
    ST_POP_PC,
    ST_POP_PSR,
    ST_RET_END
  } seq_state_e;
endpackage

// File: rtl/svc_decode.sv
module svc_decode
  import svc_seq_pkg::*;
(
  input  logic          idle_i,
  input  logic          user_i,
  input  logic          instr_valid_i,
  input  logic [DW-1:0] instr_i,
  input  logic          irq_req_i,
  output logic          start_irq_o,
  output logic          start_trap_o,
  output logic          start_ret_o,
  output logic          viol_o
);
  logic trap_hit, ret_hit, instr_slot;

  assign trap_hit   = instr_valid_i && instr_i[15:12] == OP_TRAP && instr_i[11:8] == 4'h0;
  assign ret_hit    = instr_valid_i && instr_i[15:12] == OP_RET  && instr_i[11:0] == 12'h000;
  // interrupt takes the slot ahead of any instruction
  assign instr_slot = idle_i && !irq_req_i;

  assign start_irq_o  = idle_i && irq_req_i;
  assign start_trap_o = instr_slot && trap_hit;
  assign start_ret_o  = instr_slot && ret_hit && !user_i;
  assign viol_o       = instr_slot && ret_hit && user_i;

  always_comb begin
    assert (!(start_irq_o && (start_trap_o || start_ret_o || viol_o)))
      else $error("assert_single_start_R11");
  end
endmodule

// File: rtl/svc_vec_addr.sv
module svc_vec_addr
  import svc_seq_pkg::*;
#(
  parameter int unsigned      VW        = 8,
  parameter logic [DW-1:0]    TRAP_BASE = 16'h0000,
  parameter logic [DW-1:0]    IRQ_BASE  = 16'h0100
) (
  input  logic          is_irq_i,
  input  logic [VW-1:0] vec_i,
  output logic [DW-1:0] addr_o
);
  localparam int unsigned PADW = DW - VW;
  logic [DW-1:0] vec_ext;

  assign vec_ext = {{PADW{1'b0}}, vec_i};
  assign addr_o  = (is_irq_i ? IRQ_BASE : TRAP_BASE) + vec_ext;
endmodule

// File: rtl/svc_seq.sv
module svc_seq
  import svc_seq_pkg::*;
#(
  parameter int unsigned   VW        = 8,
  parameter logic [15:0]   TRAP_BASE = 16'h0000,
  parameter logic [15:0]   IRQ_BASE  = 16'h0100,
  parameter logic [15:0]   RST_PC    = 16'h3000,
  parameter logic [15:0]   RST_SSP   = 16'h0300,
  parameter logic [15:0]   RST_USP   = 16'h4000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic [15:0]   instr_i,
  input  logic          irq_req_i,
  input  logic [VW-1:0] irq_vec_i,
  input  logic [2:0]    irq_prio_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [15:0]   mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic [15:0]   psr_o,
  output logic [15:0]   pc_o,
  output logic [15:0]   sp_o,
  output logic [15:0]   saved_ssp_o,
  output logic [15:0]   saved_usp_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          priv_viol_o
);
  seq_state_e    state_q;
  logic [DW-1:0] psr_q, pc_q, sp_q, ssp_q, usp_q, old_psr_q;
  logic [VW-1:0] vec_q;
  logic          is_irq_q, done_q, viol_q;
  logic          start_irq, start_trap, start_ret, viol;
  logic [DW-1:0] vec_addr;

  svc_decode u_decode (
    .idle_i        (state_q == ST_IDLE),
    .user_i        (psr_q[PRIV_BIT]),
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .irq_req_i     (irq_req_i),
    .start_irq_o   (start_irq),
    .start_trap_o  (start_trap),
    .start_ret_o   (start_ret),
    .viol_o        (viol)
  );

  svc_vec_addr #(
    .VW        (VW),
    .TRAP_BASE (TRAP_BASE),
    .IRQ_BASE  (IRQ_BASE)
  ) u_vec_addr (
    .is_irq_i (is_irq_q),
    .vec_i    (vec_q),
    .addr_o   (vec_addr)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = sp_q;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_PUSH_PSR: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = sp_q - 16'd1; mem_wdata_o = old_psr_q;
      end
      ST_PUSH_PC: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = sp_q - 16'd1; mem_wdata_o = pc_q;
      end
      ST_FETCH: begin
        mem_req_o = 1'b1; mem_addr_o = vec_addr;
      end
      ST_POP_PC, ST_POP_PSR: mem_req_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      psr_q     <= '0;
      pc_q      <= RST_PC;
      sp_q      <= RST_SSP;
      ssp_q     <= RST_SSP;
      usp_q     <= RST_USP;
      old_psr_q <= '0;
      vec_q     <= '0;
      is_irq_q  <= 1'b0;
      done_q    <= 1'b0;
      viol_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      viol_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_irq || start_trap) begin
            old_psr_q        <= psr_q;
            is_irq_q         <= start_irq;
            vec_q            <= start_irq ? irq_vec_i : instr_i[VW-1:0];
            psr_q[PRIV_BIT]  <= 1'b0;
            if (start_irq) psr_q[PL_LSB +: PL_W] <= irq_prio_i;
            if (psr_q[PRIV_BIT]) begin
              usp_q <= sp_q;
              sp_q  <= ssp_q;
            end
            state_q <= ST_PUSH_PSR;
          end else if (start_ret) begin
            state_q <= ST_POP_PC;
          end
          if (viol) viol_q <= 1'b1;
        end
        ST_PUSH_PSR: begin sp_q <= sp_q - 16'd1; state_q <= ST_PUSH_PC; end
        ST_PUSH_PC:  begin sp_q <= sp_q - 16'd1; state_q <= ST_FETCH;   end
        ST_FETCH:    state_q <= ST_LOAD;
        ST_LOAD: begin
          pc_q    <= mem_rdata_i;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_POP_PC:   begin sp_q <= sp_q + 16'd1; state_q <= ST_POP_PSR; end
        ST_POP_PSR: begin
          pc_q    <= mem_rdata_i;
          sp_q    <= sp_q + 16'd1;
          state_q <= ST_RET_END;
        end
        ST_RET_END: begin
          psr_q <= mem_rdata_i;
          if (mem_rdata_i[PRIV_BIT]) begin
            ssp_q <= sp_q;
            sp_q  <= usp_q;
          end
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign psr_o       = psr_q;
  assign pc_o        = pc_q;
  assign sp_o        = sp_q;
  assign saved_ssp_o = ssp_q;
  assign saved_usp_o = usp_q;
  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = done_q;
  assign priv_viol_o = viol_q;

  assert_push_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH_PSR) |=> (mem_we_o && mem_wdata_o == $past(pc_q) &&
                                  mem_addr_o == $past(mem_addr_o) - 16'd1))
    else $error("assert_push_order_R3");

  assert_entry_super_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH_PSR) |-> !psr_q[PRIV_BIT])
    else $error("assert_entry_super_R6");

  assert_user_swap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH_PSR && old_psr_q[PRIV_BIT]) |-> (sp_q == ssp_q))
    else $error("assert_user_swap_R7");

  assert_viol_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_viol_o |-> ($stable(psr_q) && $stable(sp_q) && $stable(pc_q) && !busy_o && !mem_req_o))
    else $error("assert_viol_frozen_R10");

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("assert_done_pulse_R12");

  assert_ret_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POP_PC || state_q == ST_POP_PSR) |-> (mem_req_o && !mem_we_o))
    else $error("assert_ret_no_write_R8");
endmodule

// File: tb/svc_seq_bench.sv
`timescale 1ns/1ps
module svc_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        irq_req = 1'b0;
  logic [7:0]  irq_vec = '0;
  logic [2:0]  irq_prio = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [15:0] psr, pc, sp, ssp, usp;
  logic        busy, done, viol;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] mem [0:1023];
  logic [15:0] wa [0:7];
  logic [15:0] wd [0:7];
  logic [15:0] ra [0:7];
  int nw = 0;
  int nr = 0;

  always #2 clk = ~clk;

  svc_seq u_svc_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(instr_valid), .instr_i(instr),
    .irq_req_i(irq_req), .irq_vec_i(irq_vec), .irq_prio_i(irq_prio),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .psr_o(psr), .pc_o(pc), .sp_o(sp), .saved_ssp_o(ssp), .saved_usp_o(usp),
    .busy_o(busy), .done_o(done), .priv_viol_o(viol)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[9:0]] = mem_wdata;
        if (nw < 8) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
        nw = nw + 1;
      end else begin
        mem_rdata <= mem[mem_addr[9:0]];
        if (nr < 8) ra[nr] = mem_addr;
        nr = nr + 1;
      end
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, logic [15:0] e_psr, logic [15:0] e_pc,
                           logic [15:0] e_sp, logic [15:0] e_ssp, logic [15:0] e_usp);
    chk({req, " psr"}, psr, e_psr);
    chk({req, " pc"}, pc, e_pc);
    chk({req, " sp"}, sp, e_sp);
    chk({req, " ssp"}, ssp, e_ssp);
    chk({req, " usp"}, usp, e_usp);
  endtask

  // offer one request cycle, optional busy-time noise cycle, then wait for done
  task automatic run(logic iv, logic [15:0] iw, logic irq, logic [7:0] vec,
                     logic [2:0] pr, logic noise, int exp_cyc, string req);
    int n;
    nw = 0; nr = 0;
    @(negedge clk);
    instr_valid = iv; instr = iw; irq_req = irq; irq_vec = vec; irq_prio = pr;
    @(negedge clk);
    n = 1;
    if (noise) begin
      instr_valid = 1'b1; instr = 16'hF025; irq_req = 1'b1; irq_vec = 8'h10; irq_prio = 3'd7;
      if (done) n = 99;
      @(negedge clk);
      n = n + 1;
    end
    instr_valid = 1'b0; irq_req = 1'b0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk({req, " done cycle R12"}, 16'(n), 16'(exp_cyc));
    @(negedge clk);
    chk({req, " done single R12"}, {15'd0, done}, 16'd0);
  endtask

  task automatic t_reset;
    chk_state("R1 reset", 16'h0000, 16'h3000, 16'h0300, 16'h0300, 16'h4000);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 viol", {15'd0, viol}, 16'd0);
    chk("R1 mem_req", {15'd0, mem_req}, 16'd0);
  endtask

  task automatic t_bad_trap;
    nw = 0; nr = 0;
    @(negedge clk); instr_valid = 1'b1; instr = 16'hF125;
    @(negedge clk); instr_valid = 1'b0;
    chk("R2 not busy", {15'd0, busy}, 16'd0);
    repeat (6) @(negedge clk);
    chk("R2 no access", 16'(nw + nr), 16'd0);
    chk("R2 no done", {15'd0, done}, 16'd0);
    chk_state("R2 unchanged", 16'h0000, 16'h3000, 16'h0300, 16'h0300, 16'h4000);
  endtask

  task automatic t_trap_super;
    run(1'b1, 16'hF025, 1'b0, 8'h00, 3'd0, 1'b0, 5, "trap");
    chk("R3 writes", 16'(nw), 16'd2);
    chk("R3 psr addr", wa[0], 16'h02FF);
    chk("R3 psr data", wd[0], 16'h0000);
    chk("R3 pc addr", wa[1], 16'h02FE);
    chk("R3 pc data", wd[1], 16'h3000);
    chk("R4 reads", 16'(nr), 16'd1);
    chk("R4 vec addr", ra[0], 16'h0025);
    chk_state("R4 trap end", 16'h0000, 16'h1234, 16'h02FE, 16'h0300, 16'h4000);
  endtask

  task automatic t_ret_super;
    run(1'b1, 16'h8000, 1'b0, 8'h00, 3'd0, 1'b0, 4, "ret");
    chk("R8 writes", 16'(nw), 16'd0);
    chk("R8 reads", 16'(nr), 16'd2);
    chk("R8 pc pop addr", ra[0], 16'h02FE);
    chk("R8 psr pop addr", ra[1], 16'h02FF);
    chk_state("R8 ret end", 16'h0000, 16'h3000, 16'h0300, 16'h0300, 16'h4000);
  endtask

  task automatic t_ret_to_user;
    run(1'b1, 16'hF025, 1'b0, 8'h00, 3'd0, 1'b0, 5, "trap2");
    mem[10'h2FE] = 16'h3100;
    mem[10'h2FF] = 16'h8300;
    run(1'b1, 16'h8000, 1'b0, 8'h00, 3'd0, 1'b0, 4, "ret user");
    chk_state("R9 to user", 16'h8300, 16'h3100, 16'h4000, 16'h0300, 16'h4000);
  endtask

  task automatic t_viol;
    nw = 0; nr = 0;
    @(negedge clk); instr_valid = 1'b1; instr = 16'h8000;
    @(negedge clk); instr_valid = 1'b0;
    chk("R10 viol high", {15'd0, viol}, 16'd1);
    chk("R10 not busy", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R10 viol one cycle", {15'd0, viol}, 16'd0);
    @(negedge clk); instr_valid = 1'b1; instr = 16'h8001;
    @(negedge clk); instr_valid = 1'b0;
    chk("R10 malformed no viol", {15'd0, viol}, 16'd0);
    repeat (4) @(negedge clk);
    chk("R10 no access", 16'(nw + nr), 16'd0);
    chk_state("R10 unchanged", 16'h8300, 16'h3100, 16'h4000, 16'h0300, 16'h4000);
  endtask

  task automatic t_trap_user;
    run(1'b1, 16'hF025, 1'b0, 8'h00, 3'd0, 1'b0, 5, "trap user");
    chk("R7 psr addr", wa[0], 16'h02FF);
    chk("R7 psr data", wd[0], 16'h8300);
    chk("R7 pc addr", wa[1], 16'h02FE);
    chk("R7 pc data", wd[1], 16'h3100);
    chk_state("R6 R7 trap user", 16'h0300, 16'h1234, 16'h02FE, 16'h0300, 16'h4000);
  endtask

  task automatic t_irq_collide;
    run(1'b1, 16'hF025, 1'b1, 8'h80, 3'd6, 1'b1, 5, "irq");
    chk("R11 writes", 16'(nw), 16'd2);
    chk("R11 reads", 16'(nr), 16'd1);
    chk("R5 vec addr", ra[0], 16'h0180);
    chk("R5 psr data", wd[0], 16'h0300);
    chk("R5 psr addr", wa[0], 16'h02FD);
    chk("R5 pc data", wd[1], 16'h1234);
    chk_state("R5 irq end", 16'h0600, 16'h2200, 16'h02FC, 16'h0300, 16'h4000);
    repeat (4) @(negedge clk);
    chk("R11 no late sequence", {15'd0, busy}, 16'd0);
  endtask

  task automatic t_unwind;
    run(1'b1, 16'h8000, 1'b0, 8'h00, 3'd0, 1'b0, 4, "ret irq");
    chk_state("R8 ret irq", 16'h0300, 16'h1234, 16'h02FE, 16'h0300, 16'h4000);
    run(1'b1, 16'h8000, 1'b0, 8'h00, 3'd0, 1'b0, 4, "ret trap");
    chk_state("R9 back to user", 16'h8300, 16'h3100, 16'h4000, 16'h0300, 16'h4000);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    mem[10'h025] = 16'h1234;
    mem[10'h180] = 16'h2200;
    mem[10'h110] = 16'hDEAD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_trap();
    t_trap_super();
    t_ret_super();
    t_ret_to_user();
    t_viol();
    t_trap_user();
    t_irq_collide();
    t_unwind();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule